// File: doc/BRIEF.md
# Descriptor Region Address Translator

This block maps descriptor byte addresses to global link indices and back. Software fills a small table of descriptor memory regions. Each entry gives four things:

- a base byte address;
- the first link index that the region owns;
- the descriptor size, as a power of two in bytes;
- the descriptor count, as a power of two.

A queue engine uses the block in two directions. On a push, it hands the block an address and gets back the link index. On a pop, it hands the block an index and gets back the address. Each direction is its own pipelined lookup port.

Each lookup port is a valid/ready stream. A request is accepted on a clock edge where both `*_req_valid` and `*_req_ready` are high. Its response appears on the `*_rsp_*` pins two clock edges later. The response holds steady while `*_rsp_valid` is high and `*_rsp_ready` is low. While a response is held, the whole two-stage pipe of that port stalls and `*_req_ready` stays low.

The programming port is a plain single-cycle write strobe. A write that describes a malformed region, or a region whose index range collides with another enabled region, leaves the table untouched and raises a status bit.

Top module: `desc_region_xlat`

## Requirements
- R1: After reset every region is disabled, `cfg_reject` is 0, both response valids are 0, and both request readies are 1.
- R2: A write is rejected in any of these cases: the selected entry is 20 or higher; or the write enables a region and the base address has a nonzero bit in its low 4 bits, or the size exponent is below 5, or the count exponent is below 5 or above 19. A rejected write sets `cfg_reject` to 1 on the next edge and changes no table entry.
- R3: A write that enables a region whose index range [start, start + 2^count) intersects the range of any other enabled entry is rejected, and the table keeps its prior contents.
- R4: A write is rejected when its index range ends past 2^19 or its byte range ends past 2^32. A range that ends exactly at either limit is accepted.
- R5: A push lookup returns index = start + (address − base) >> size exponent. It uses the region that holds the address, meaning base ≤ address < base + 2^(size+count), and returns `push_rsp_err` = 0.
- R6: A push address that lies in no enabled region, or whose offset is not a multiple of the descriptor size, returns `push_rsp_err` = 1 with `push_rsp_idx` = 0.
- R7: A pop lookup returns address = base + (index − start) << size exponent, using the enabled region whose index range holds the index, with `pop_rsp_err` = 0.
- R8: A pop index that lies in no enabled region returns `pop_rsp_err` = 1 with `pop_rsp_addr` = 0.
- R9: A response appears exactly two edges after acceptance when `*_rsp_ready` is high. A response waiting with ready low holds its value, and `*_req_ready` is low during the stall.
- R10: When enabled regions overlap in byte address, a push takes the lowest-numbered entry among them.
- R11: A write with `cfg_en` = 0 to a valid entry is always accepted, clears `cfg_reject` like any accepted write, and removes that region from both lookups.
- R12: A lookup accepted on the same edge as a table write is translated with the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 5 | Entry number to write |
| cfg_en | input | 1 | 1 = enable the entry with the fields below, 0 = disable it |
| cfg_base | input | 32 | Region base byte address |
| cfg_start | input | 19 | First link index of the region |
| cfg_size_lg | input | 5 | log2 of the descriptor size in bytes |
| cfg_cnt_lg | input | 5 | log2 of the descriptor count |
| cfg_reject | output | 1 | 1 if the most recent write was rejected |
| push_req_valid | input | 1 | Address lookup request valid |
| push_req_ready | output | 1 | Address lookup request accepted |
| push_addr | input | 32 | Descriptor byte address to translate |
| push_rsp_valid | output | 1 | Index result valid |
| push_rsp_ready | input | 1 | Consumer takes the index result |
| push_rsp_idx | output | 19 | Link index result |
| push_rsp_err | output | 1 | Address not translatable |
| pop_req_valid | input | 1 | Index lookup request valid |
| pop_req_ready | output | 1 | Index lookup request accepted |
| pop_idx | input | 19 | Link index to translate |
| pop_rsp_valid | output | 1 | Address result valid |
| pop_rsp_ready | input | 1 | Consumer takes the address result |
| pop_rsp_addr | output | 32 | Descriptor byte address result |
| pop_rsp_err | output | 1 | Index not translatable |

## Verification
A table write and a lookup on either port can fall on the same clock edge. The bench provokes this with one test: on a single cycle it disables a region while a pop request and a push request hit the table. The in-flight pop must still resolve through the disabled region. A pop issued right after the write must report an error. The push and pop ports are also driven together on that edge to show that their results stay independent.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int BASE_ALIGN_LG = 4;
  localparam int MIN_SIZE_LG   = 5;
  localparam int MIN_COUNT_LG  = 5;
endpackage

// File: rtl/xlat_region_table.sv
module xlat_region_table #(
  parameter int N      = 20,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 19,
  parameter int LG_W   = 5,
  parameter int RID_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RID_W-1:0]  cfg_sel,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [LG_W-1:0]   cfg_size_lg,
  input  logic [LG_W-1:0]   cfg_cnt_lg,
  output logic              cfg_reject,
  output logic [N-1:0]      rg_en,
  output logic [ADDR_W-1:0] rg_base    [N],
  output logic [IDX_W-1:0]  rg_start   [N],
  output logic [LG_W-1:0]   rg_size_lg [N],
  output logic [LG_W-1:0]   rg_cnt_lg  [N]
);
  import xlat_pkg::*;
  localparam int SUM_W = LG_W + 1;

  logic [SUM_W-1:0]  lg_sum;
  logic [ADDR_W:0]   a_end;
  logic [IDX_W:0]    i_end;
  logic [IDX_W:0]    rg_iend [N];
  logic              sel_ok, shape_ok, clash, accept;

  assign lg_sum = {1'b0, cfg_size_lg} + {1'b0, cfg_cnt_lg};
  assign a_end  = {1'b0, cfg_base} + ((ADDR_W+1)'(1) << lg_sum);
  assign i_end  = {1'b0, cfg_start} + ((IDX_W+1)'(1) << cfg_cnt_lg);
  assign sel_ok = {1'b0, cfg_sel} < (RID_W+1)'(N);

  for (genvar j = 0; j < N; j++) begin : g_iend
    assign rg_iend[j] = {1'b0, rg_start[j]} + ((IDX_W+1)'(1) << rg_cnt_lg[j]);
  end

  always_comb begin
    shape_ok = (cfg_base[BASE_ALIGN_LG-1:0] == '0)
            && (cfg_size_lg >= LG_W'(MIN_SIZE_LG))
            && (cfg_cnt_lg >= LG_W'(MIN_COUNT_LG))
            && (cfg_cnt_lg <= LG_W'(IDX_W))
            && (lg_sum <= SUM_W'(ADDR_W))
            && (a_end <= ((ADDR_W+1)'(1) << ADDR_W))
            && (i_end <= ((IDX_W+1)'(1) << IDX_W));
    clash = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (rg_en[j] && (RID_W'(j) != cfg_sel)
          && ({1'b0, cfg_start} < rg_iend[j])
          && ({1'b0, rg_start[j]} < i_end))
        clash = 1'b1;
    end
    accept = sel_ok && (!cfg_en || (shape_ok && !clash));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_reject <= 1'b0;
      rg_en      <= '0;
      for (int i = 0; i < N; i++) begin
        rg_base[i]    <= '0;
        rg_start[i]   <= '0;
        rg_size_lg[i] <= '0;
        rg_cnt_lg[i]  <= '0;
      end
    end else if (cfg_we) begin
      cfg_reject <= !accept;
      for (int i = 0; i < N; i++) begin
        if (accept && (cfg_sel == RID_W'(i))) begin
          rg_en[i]      <= cfg_en;
          rg_base[i]    <= cfg_base;
          rg_start[i]   <= cfg_start;
          rg_size_lg[i] <= cfg_size_lg;
          rg_cnt_lg[i]  <= cfg_cnt_lg;
        end
      end
    end
  end

  // Checks: enabled index ranges stay pairwise disjoint; rejects leave the table alone
  logic tbl_overlap;
  always_comb begin
    tbl_overlap = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (rg_en[a] && rg_en[b] && ({1'b0, rg_start[a]} < rg_iend[b])
            && ({1'b0, rg_start[b]} < rg_iend[a]))
          tbl_overlap = 1'b1;
  end

  p_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n) !tbl_overlap);

  p_reject_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !accept) |=> (cfg_reject && $stable(rg_en)));
endmodule

// File: rtl/xlat_push_path.sv
module xlat_push_path #(
  parameter int N      = 20,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 19,
  parameter int LG_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      rg_en,
  input  logic [ADDR_W-1:0] rg_base    [N],
  input  logic [IDX_W-1:0]  rg_start   [N],
  input  logic [LG_W-1:0]   rg_size_lg [N],
  input  logic [LG_W-1:0]   rg_cnt_lg  [N],
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              rsp_err
);
  logic              adv;
  logic [N-1:0]      hit_vec;
  logic [ADDR_W-1:0] off_r [N];
  logic              s1_valid, s1_hit;
  logic [ADDR_W-1:0] s1_off;
  logic [IDX_W-1:0]  s1_start;
  logic [LG_W-1:0]   s1_size_lg;
  logic              pick_hit;
  logic [ADDR_W-1:0] pick_off;
  logic [IDX_W-1:0]  pick_start;
  logic [LG_W-1:0]   pick_size_lg;

  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;

  for (genvar r = 0; r < N; r++) begin : g_cmp
    assign off_r[r]   = req_addr - rg_base[r];
    assign hit_vec[r] = rg_en[r] && (req_addr >= rg_base[r])
                     && ((off_r[r] >> ({1'b0, rg_size_lg[r]} + {1'b0, rg_cnt_lg[r]})) == '0);
  end

  // lowest-numbered hit wins
  always_comb begin
    pick_hit = 1'b0; pick_off = '0; pick_start = '0; pick_size_lg = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        pick_hit = 1'b1; pick_off = off_r[r];
        pick_start = rg_start[r]; pick_size_lg = rg_size_lg[r];
      end
    end
  end

  logic [ADDR_W-1:0] lo_mask;
  logic [IDX_W-1:0]  idx_calc;
  logic              aligned;
  assign lo_mask  = ~({ADDR_W{1'b1}} << s1_size_lg);
  assign aligned  = (s1_off & lo_mask) == '0;
  assign idx_calc = s1_start + IDX_W'(s1_off >> s1_size_lg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_hit <= 1'b0; s1_off <= '0; s1_start <= '0; s1_size_lg <= '0;
      rsp_valid <= 1'b0; rsp_idx <= '0; rsp_err <= 1'b0;
    end else if (adv) begin
      s1_valid   <= req_valid;
      s1_hit     <= pick_hit;
      s1_off     <= pick_off;
      s1_start   <= pick_start;
      s1_size_lg <= pick_size_lg;
      rsp_valid  <= s1_valid;
      rsp_err    <= !(s1_hit && aligned);
      rsp_idx    <= (s1_hit && aligned) ? idx_calc : '0;
    end
  end

  logic in_fire;
  assign in_fire = req_valid && req_ready;

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(in_fire, 2) && $past(adv)) |-> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_idx) && $stable(rsp_err)));
endmodule

// File: rtl/xlat_pop_path.sv
module xlat_pop_path #(
  parameter int N      = 20,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 19,
  parameter int LG_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      rg_en,
  input  logic [ADDR_W-1:0] rg_base    [N],
  input  logic [IDX_W-1:0]  rg_start   [N],
  input  logic [LG_W-1:0]   rg_size_lg [N],
  input  logic [LG_W-1:0]   rg_cnt_lg  [N],
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_err
);
  logic              adv;
  logic [N-1:0]      hit_vec;
  logic [IDX_W-1:0]  rel_r [N];
  logic              s1_valid, s1_hit;
  logic [IDX_W-1:0]  s1_rel;
  logic [ADDR_W-1:0] s1_base;
  logic [LG_W-1:0]   s1_size_lg;
  logic              pick_hit;
  logic [IDX_W-1:0]  pick_rel;
  logic [ADDR_W-1:0] pick_base;
  logic [LG_W-1:0]   pick_size_lg;

  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;

  for (genvar r = 0; r < N; r++) begin : g_cmp
    assign rel_r[r]   = req_idx - rg_start[r];
    assign hit_vec[r] = rg_en[r] && (req_idx >= rg_start[r])
                     && ((rel_r[r] >> rg_cnt_lg[r]) == '0);
  end

  always_comb begin
    pick_hit = 1'b0; pick_rel = '0; pick_base = '0; pick_size_lg = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (hit_vec[r]) begin
        pick_hit = 1'b1; pick_rel = rel_r[r];
        pick_base = rg_base[r]; pick_size_lg = rg_size_lg[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_hit <= 1'b0; s1_rel <= '0; s1_base <= '0; s1_size_lg <= '0;
      rsp_valid <= 1'b0; rsp_addr <= '0; rsp_err <= 1'b0;
    end else if (adv) begin
      s1_valid   <= req_valid;
      s1_hit     <= pick_hit;
      s1_rel     <= pick_rel;
      s1_base    <= pick_base;
      s1_size_lg <= pick_size_lg;
      rsp_valid  <= s1_valid;
      rsp_err    <= !s1_hit;
      rsp_addr   <= s1_hit ? (s1_base + (ADDR_W'(s1_rel) << s1_size_lg)) : '0;
    end
  end

  logic in_fire;
  assign in_fire = req_valid && req_ready;

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(in_fire, 2) && $past(adv)) |-> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_err)));

  p_err_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_addr == '0));
endmodule

// File: rtl/desc_region_xlat.sv
module desc_region_xlat #(
  parameter int NUM_REGIONS = 20,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 19,
  parameter int LG_W        = 5,
  localparam int RID_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RID_W-1:0]  cfg_sel,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [LG_W-1:0]   cfg_size_lg,
  input  logic [LG_W-1:0]   cfg_cnt_lg,
  output logic              cfg_reject,
  input  logic              push_req_valid,
  output logic              push_req_ready,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              push_rsp_valid,
  input  logic              push_rsp_ready,
  output logic [IDX_W-1:0]  push_rsp_idx,
  output logic              push_rsp_err,
  input  logic              pop_req_valid,
  output logic              pop_req_ready,
  input  logic [IDX_W-1:0]  pop_idx,
  output logic              pop_rsp_valid,
  input  logic              pop_rsp_ready,
  output logic [ADDR_W-1:0] pop_rsp_addr,
  output logic              pop_rsp_err
);
  logic [NUM_REGIONS-1:0] rg_en;
  logic [ADDR_W-1:0]      rg_base    [NUM_REGIONS];
  logic [IDX_W-1:0]       rg_start   [NUM_REGIONS];
  logic [LG_W-1:0]        rg_size_lg [NUM_REGIONS];
  logic [LG_W-1:0]        rg_cnt_lg  [NUM_REGIONS];

  xlat_region_table #(.N(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LG_W(LG_W), .RID_W(RID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_start(cfg_start), .cfg_size_lg(cfg_size_lg), .cfg_cnt_lg(cfg_cnt_lg),
    .cfg_reject(cfg_reject), .rg_en(rg_en), .rg_base(rg_base), .rg_start(rg_start),
    .rg_size_lg(rg_size_lg), .rg_cnt_lg(rg_cnt_lg));

  xlat_push_path #(.N(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LG_W(LG_W)) u_push (
    .clk(clk), .rst_n(rst_n), .rg_en(rg_en), .rg_base(rg_base), .rg_start(rg_start),
    .rg_size_lg(rg_size_lg), .rg_cnt_lg(rg_cnt_lg),
    .req_valid(push_req_valid), .req_ready(push_req_ready), .req_addr(push_addr),
    .rsp_valid(push_rsp_valid), .rsp_ready(push_rsp_ready), .rsp_idx(push_rsp_idx),
    .rsp_err(push_rsp_err));

  xlat_pop_path #(.N(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LG_W(LG_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .rg_en(rg_en), .rg_base(rg_base), .rg_start(rg_start),
    .rg_size_lg(rg_size_lg), .rg_cnt_lg(rg_cnt_lg),
    .req_valid(pop_req_valid), .req_ready(pop_req_ready), .req_idx(pop_idx),
    .rsp_valid(pop_rsp_valid), .rsp_ready(pop_rsp_ready), .rsp_addr(pop_rsp_addr),
    .rsp_err(pop_rsp_err));
endmodule

// File: tb/desc_region_xlat_tb.sv
module desc_region_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_sel = '0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [18:0] cfg_start = '0;
  logic [4:0]  cfg_size_lg = '0;
  logic [4:0]  cfg_cnt_lg = '0;
  logic        cfg_reject;
  logic        push_req_valid = 1'b0, push_req_ready;
  logic [31:0] push_addr = '0;
  logic        push_rsp_valid, push_rsp_ready = 1'b1;
  logic [18:0] push_rsp_idx;
  logic        push_rsp_err;
  logic        pop_req_valid = 1'b0, pop_req_ready;
  logic [18:0] pop_idx = '0;
  logic        pop_rsp_valid, pop_rsp_ready = 1'b1;
  logic [31:0] pop_rsp_addr;
  logic        pop_rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  desc_region_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_start(cfg_start), .cfg_size_lg(cfg_size_lg), .cfg_cnt_lg(cfg_cnt_lg),
    .cfg_reject(cfg_reject),
    .push_req_valid(push_req_valid), .push_req_ready(push_req_ready), .push_addr(push_addr),
    .push_rsp_valid(push_rsp_valid), .push_rsp_ready(push_rsp_ready),
    .push_rsp_idx(push_rsp_idx), .push_rsp_err(push_rsp_err),
    .pop_req_valid(pop_req_valid), .pop_req_ready(pop_req_ready), .pop_idx(pop_idx),
    .pop_rsp_valid(pop_rsp_valid), .pop_rsp_ready(pop_rsp_ready),
    .pop_rsp_addr(pop_rsp_addr), .pop_rsp_err(pop_rsp_err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [4:0] sel, input logic en, input logic [31:0] base,
                     input logic [18:0] start, input logic [4:0] slg, input logic [4:0] clg,
                     input logic exp_rej, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_base = base;
    cfg_start = start; cfg_size_lg = slg; cfg_cnt_lg = clg;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, 64'(cfg_reject), 64'(exp_rej));
  endtask

  task automatic do_push(input logic [31:0] a, input logic e_err, input logic [18:0] e_idx,
                         input string req);
    @(negedge clk);
    push_req_valid = 1'b1; push_addr = a;
    @(negedge clk);
    push_req_valid = 1'b0;
    chk({req, " latency"}, 64'(push_rsp_valid), 64'd0);
    @(negedge clk);
    chk({req, " valid"}, 64'(push_rsp_valid), 64'd1);
    chk({req, " err"}, 64'(push_rsp_err), 64'(e_err));
    chk({req, " idx"}, 64'(push_rsp_idx), 64'(e_idx));
  endtask

  task automatic do_pop(input logic [18:0] i, input logic e_err, input logic [31:0] e_addr,
                        input string req);
    @(negedge clk);
    pop_req_valid = 1'b1; pop_idx = i;
    @(negedge clk);
    pop_req_valid = 1'b0;
    chk({req, " latency"}, 64'(pop_rsp_valid), 64'd0);
    @(negedge clk);
    chk({req, " valid"}, 64'(pop_rsp_valid), 64'd1);
    chk({req, " err"}, 64'(pop_rsp_err), 64'(e_err));
    chk({req, " addr"}, 64'(pop_rsp_addr), 64'(e_addr));
  endtask

  task automatic t_reset_r1;
    chk("R1 reject", 64'(cfg_reject), 64'd0);
    chk("R1 push valid", 64'(push_rsp_valid), 64'd0);
    chk("R1 pop valid", 64'(pop_rsp_valid), 64'd0);
    chk("R1 push ready", 64'(push_req_ready), 64'd1);
    chk("R1 pop ready", 64'(pop_req_ready), 64'd1);
    do_pop(19'd0, 1'b1, 32'd0, "R1 empty table pop");
    do_push(32'h1000_0000, 1'b1, 19'd0, "R1 empty table push");
  endtask

  task automatic t_translate_r5_r7;
    cfg(5'd0, 1'b1, 32'h1000_0000, 19'd0, 5'd6, 5'd5, 1'b0, "R5 program entry 0");
    cfg(5'd3, 1'b1, 32'h2000_0000, 19'd32, 5'd7, 5'd8, 1'b0, "R5 program entry 3");
    do_push(32'h1000_0000, 1'b0, 19'd0, "R5 first descriptor");
    do_push(32'h1000_07C0, 1'b0, 19'd31, "R5 last descriptor entry 0");
    do_push(32'h2000_0080, 1'b0, 19'd33, "R5 entry 3 second");
    do_push(32'h2000_7F80, 1'b0, 19'd287, "R5 entry 3 last");
    do_pop(19'd31, 1'b0, 32'h1000_07C0, "R7 index 31");
    do_pop(19'd287, 1'b0, 32'h2000_7F80, "R7 index 287");
    do_pop(19'd40, 1'b0, 32'h2000_0400, "R7 index 40");
  endtask

  task automatic t_invalid_r6_r8;
    do_push(32'h1000_0010, 1'b1, 19'd0, "R6 misaligned");
    do_push(32'h1000_0800, 1'b1, 19'd0, "R6 one past end");
    do_push(32'h0FFF_FFC0, 1'b1, 19'd0, "R6 below base");
    do_pop(19'd288, 1'b1, 32'd0, "R8 index past range");
    do_pop(19'd500, 1'b1, 32'd0, "R8 unmapped index");
  endtask

  task automatic t_shape_r2;
    cfg(5'd5, 1'b1, 32'h3000_0008, 19'd288, 5'd5, 5'd5, 1'b1, "R2 misaligned base");
    do_pop(19'd288, 1'b1, 32'd0, "R2 table unchanged after reject");
    cfg(5'd5, 1'b1, 32'h3000_0000, 19'd288, 5'd4, 5'd5, 1'b1, "R2 size too small");
    cfg(5'd5, 1'b1, 32'h3000_0000, 19'd288, 5'd5, 5'd4, 1'b1, "R2 count too small");
    cfg(5'd21, 1'b1, 32'h3000_0000, 19'd288, 5'd5, 5'd5, 1'b1, "R2 entry out of range");
    cfg(5'd5, 1'b1, 32'h3000_0000, 19'd288, 5'd5, 5'd5, 1'b0, "R2 good write clears reject");
    do_pop(19'd288, 1'b0, 32'h3000_0000, "R2 accepted entry usable");
  endtask

  task automatic t_overlap_r3;
    cfg(5'd6, 1'b1, 32'h5000_0000, 19'd300, 5'd5, 5'd5, 1'b1, "R3 overlap rejected");
    do_pop(19'd330, 1'b1, 32'd0, "R3 rejected range unmapped");
    do_pop(19'd300, 1'b0, 32'h3000_0180, "R3 existing mapping kept");
  endtask

  task automatic t_limits_r4;
    cfg(5'd8, 1'b1, 32'h4000_0000, 19'd524272, 5'd5, 5'd5, 1'b1, "R4 index past limit");
    cfg(5'd8, 1'b1, 32'h4000_0000, 19'd524256, 5'd5, 5'd5, 1'b0, "R4 index at limit");
    do_pop(19'd524287, 1'b0, 32'h4000_03E0, "R4 top index");
    cfg(5'd7, 1'b1, 32'hFFFF_F000, 19'd1000, 5'd8, 5'd5, 1'b1, "R4 bytes past limit");
    cfg(5'd7, 1'b1, 32'hFFFF_F000, 19'd1000, 5'd7, 5'd5, 1'b0, "R4 bytes at limit");
    do_push(32'hFFFF_FF80, 1'b0, 19'd1031, "R4 top address");
  endtask

  task automatic t_priority_r10;
    cfg(5'd1, 1'b1, 32'h1000_0000, 19'd2000, 5'd6, 5'd5, 1'b0, "R10 aliasing entry accepted");
    do_push(32'h1000_0040, 1'b0, 19'd1, "R10 lowest entry wins");
    do_pop(19'd2001, 1'b0, 32'h1000_0040, "R10 alias pop");
  endtask

  task automatic t_disable_r11;
    cfg(5'd5, 1'b1, 32'h3000_0004, 19'd288, 5'd5, 5'd5, 1'b1, "R11 set reject first");
    cfg(5'd0, 1'b0, 32'h0, 19'd0, 5'd0, 5'd0, 1'b0, "R11 disable accepted");
    do_push(32'h1000_0040, 1'b0, 19'd2001, "R11 push falls to next entry");
    do_pop(19'd1, 1'b1, 32'd0, "R11 pop disabled range");
  endtask

  task automatic t_same_cycle_r12;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 5'd1; cfg_en = 1'b0;
    pop_req_valid = 1'b1; pop_idx = 19'd2001;
    push_req_valid = 1'b1; push_addr = 32'h2000_0080;
    @(negedge clk);
    cfg_we = 1'b0; pop_req_valid = 1'b0; push_req_valid = 1'b0;
    chk("R12 disable accepted", 64'(cfg_reject), 64'd0);
    @(negedge clk);
    chk("R12 pop valid", 64'(pop_rsp_valid), 64'd1);
    chk("R12 pop sees old table", 64'(pop_rsp_err), 64'd0);
    chk("R12 pop old addr", 64'(pop_rsp_addr), 64'h1000_0040);
    chk("R12 push same edge valid", 64'(push_rsp_valid), 64'd1);
    chk("R12 push same edge idx", 64'(push_rsp_idx), 64'd33);
    do_pop(19'd2001, 1'b1, 32'd0, "R12 next pop sees new table");
  endtask

  task automatic t_backpressure_r9;
    @(negedge clk);
    push_rsp_ready = 1'b0;
    push_req_valid = 1'b1; push_addr = 32'h2000_0080;
    @(negedge clk);
    push_req_valid = 1'b0;
    @(negedge clk);
    chk("R9 stalled valid", 64'(push_rsp_valid), 64'd1);
    chk("R9 stalled ready low", 64'(push_req_ready), 64'd0);
    push_req_valid = 1'b1; push_addr = 32'h1000_0000;
    repeat (3) @(negedge clk);
    push_req_valid = 1'b0;
    chk("R9 held idx", 64'(push_rsp_idx), 64'd33);
    chk("R9 held valid", 64'(push_rsp_valid), 64'd1);
    push_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", 64'(push_rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_translate_r5_r7();
    t_invalid_r6_r8();
    t_shape_r2();
    t_overlap_r3();
    t_limits_r4();
    t_priority_r10();
    t_disable_r11();
    t_same_cycle_r12();
    t_backpressure_r9();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule